// File: doc/BRIEF.md
# Cursor Register Arming Bank

This block holds the software-visible registers of a hardware cursor plane. There are four of them: control, position, surface base address and a height override. Every register write lands in a pending copy. The display side uses a second, live copy. The pending values move into the live copy only at a vertical-blank pulse, and only if an update has been armed beforehand. Because of this, the order in which software writes the registers decides which values reach the screen.

Writing the base-address register arms an update. When the live cursor is disabled, a control write that selects a nonzero cursor mode also arms the update. Any other write that arrives while an update is armed disarms it, and the update stays pending until software arms it again. A position write therefore never reaches the screen on its own. The live side also decodes the cursor geometry. The mode field selects a square cursor of 64, 128 or 256 pixels. The height override makes the cursor shorter when software sets the override's enable bit.

Top module: `cur_arm_bank`

## Requirements
- R1: After reset, all pending registers, all live registers and the armed flag are zero.
- R2: A write to address 2 (base) sets the armed flag at the write's clock edge.
- R3: If the live control mode field (control bits [1:0], address 0) is zero, a control write with a nonzero mode field sets the armed flag.
- R4: While armed, a write that does not itself arm clears the flag. This covers writes to address 1 (position), to address 3 (height), and control writes made while the live cursor is enabled. Such a control write never arms.
- R5: At a clock edge where vblank is high and the flag is set, all four live registers take the pending values and the flag clears.
- R6: At a clock edge where vblank is low or the flag is clear, every live register keeps its value.
- R7: A position write with no later arming write never changes the live position, even across vblank pulses.
- R8: The read port returns the pending register chosen by the read address, and a status output reports the armed flag.
- R9: Live mode 0 means the cursor is disabled, with width 0. Modes 1, 2 and 3 give widths of 64, 128 and 256 pixels.
- R10: The height register holds an enable bit in bit 31 and height minus one in bits [7:0]. When the cursor is enabled and the enable bit is set, the live height is that value plus one. Otherwise the height equals the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 position, 2 base, 3 height |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Pending value at rd_addr |
| upd_armed | output | 1 | An update is armed |
| vblank | input | 1 | Vertical-blank pulse |
| live_ctrl | output | 32 | Live control register |
| live_pos | output | 32 | Live position register |
| live_base | output | 32 | Live base address register |
| live_hgt | output | 32 | Live height override register |
| live_enable | output | 1 | Live cursor is enabled |
| live_width | output | 9 | Live cursor width in pixels |
| live_height | output | 9 | Live cursor height in lines |

## Verification
The assertions assume that the write strobe, the address and vblank are clean single-cycle samples, and that a write and a vblank may share a cycle. The transfer property is checked only in cycles with no write, because a write in the same cycle can re-arm the flag. The bench never drives a write and a vblank together. It issues each write and each vblank as a one-cycle pulse away from the clock edge. It also keeps the height value no larger than the width selected by the mode, which is the range the geometry checks assume.

// File: rtl/cur_arm_pkg.sv
package cur_arm_pkg;
    localparam int REG_W   = 32;
    localparam int NREG    = 4;
    localparam int ADDR_W  = $clog2(NREG);
    localparam int MODE_W  = 2;
    localparam int HGT_W   = 8;
    localparam int MIN_LOG = 6;
    localparam int GEO_W   = HGT_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_POS  = 2'd1,
        SEL_BASE = 2'd2,
        SEL_HGT  = 2'd3
    } reg_sel_e;

    typedef logic [NREG-1:0][REG_W-1:0] reg_arr_t;
endpackage

// File: rtl/cur_wr_decode.sv
module cur_wr_decode
    import cur_arm_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [MODE_W-1:0]    live_mode,
    output logic [NREG-1:0]      wr_sel,
    output logic                 arm_req,
    output logic                 cancel_req
);
    logic enabling;

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (wr_addr == ADDR_W'(g));
    end

    always_comb begin
        enabling   = wr_sel[SEL_CTRL] && (live_mode == '0) &&
                     (wr_data[MODE_W-1:0] != '0);
        arm_req    = wr_sel[SEL_BASE] || enabling;
        cancel_req = wr_en && !arm_req;
    end
endmodule

// File: rtl/cur_shadow_bank.sv
module cur_shadow_bank
    import cur_arm_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREG-1:0]      wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 arm_req,
    input  logic                 cancel_req,
    input  logic                 vblank,
    output reg_arr_t             pend,
    output logic                 armed,
    output logic                 xfer
);
    typedef struct packed {
        reg_arr_t regs;
        logic     armed;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_sel[i]) st_d.regs[i] = wr_data;
        end
        if (arm_req)
            st_d.armed = 1'b1;
        else if (cancel_req)
            st_d.armed = 1'b0;
        else if (vblank && st_q.armed)
            st_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend  = st_q.regs;
    assign armed = st_q.armed;
    assign xfer  = vblank && st_q.armed;
endmodule

// File: rtl/cur_live_bank.sv
module cur_live_bank
    import cur_arm_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer,
    input  reg_arr_t             pend,
    output reg_arr_t             live,
    output logic                 enable,
    output logic [GEO_W-1:0]     width,
    output logic [GEO_W-1:0]     height
);
    reg_arr_t live_d, live_q;
    logic [MODE_W-1:0] mode;
    logic              hgt_en;

    always_comb begin
        live_d = xfer ? pend : live_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    always_comb begin
        mode   = live_q[SEL_CTRL][MODE_W-1:0];
        hgt_en = live_q[SEL_HGT][DATA_W-1];
        enable = (mode != '0);
        width  = '0;
        height = '0;
        if (enable) begin
            width = GEO_W'(1) << (MIN_LOG + int'(mode) - 1);
            if (hgt_en)
                height = GEO_W'(live_q[SEL_HGT][HGT_W-1:0]) + GEO_W'(1);
            else
                height = width;
        end
    end

    assign live = live_q;
endmodule

// File: rtl/cur_arm_bank.sv
module cur_arm_bank
    import cur_arm_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 upd_armed,
    input  logic                 vblank,
    output logic [DATA_W-1:0]    live_ctrl,
    output logic [DATA_W-1:0]    live_pos,
    output logic [DATA_W-1:0]    live_base,
    output logic [DATA_W-1:0]    live_hgt,
    output logic                 live_enable,
    output logic [GEO_W-1:0]     live_width,
    output logic [GEO_W-1:0]     live_height
);
    logic [NREG-1:0] wr_sel;
    logic            arm_req, cancel_req, xfer;
    reg_arr_t        pend, live;

    cur_wr_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .live_mode  (live[SEL_CTRL][MODE_W-1:0]),
        .wr_sel     (wr_sel),
        .arm_req    (arm_req),
        .cancel_req (cancel_req)
    );

    cur_shadow_bank #(.DATA_W(DATA_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .arm_req    (arm_req),
        .cancel_req (cancel_req),
        .vblank     (vblank),
        .pend       (pend),
        .armed      (upd_armed),
        .xfer       (xfer)
    );

    cur_live_bank #(.DATA_W(DATA_W)) u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .xfer   (xfer),
        .pend   (pend),
        .live   (live),
        .enable (live_enable),
        .width  (live_width),
        .height (live_height)
    );

    assign rd_data   = pend[rd_addr];
    assign live_ctrl = live[SEL_CTRL];
    assign live_pos  = live[SEL_POS];
    assign live_base = live[SEL_BASE];
    assign live_hgt  = live[SEL_HGT];
endmodule

// File: rtl/cur_arm_bank_chk.sv
module cur_arm_bank_chk
    import cur_arm_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic               vblank,
    input logic               upd_armed,
    input reg_arr_t           pend,
    input logic [DATA_W-1:0]  live_ctrl,
    input logic [DATA_W-1:0]  live_pos,
    input logic [DATA_W-1:0]  live_base,
    input logic [DATA_W-1:0]  live_hgt,
    input logic               live_enable,
    input logic [GEO_W-1:0]   live_width,
    input logic [GEO_W-1:0]   live_height
);
    assert_base_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_BASE) |=> upd_armed);

    assert_enable_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_CTRL && live_ctrl[MODE_W-1:0] == '0 &&
         wr_data[MODE_W-1:0] != '0) |=> upd_armed);

    assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == SEL_POS || wr_addr == SEL_HGT)) |=> !upd_armed);

    assert_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_armed && vblank && !wr_en) |=>
            (!upd_armed && live_base == $past(pend[SEL_BASE]) &&
             live_pos == $past(pend[SEL_POS]) &&
             live_ctrl == $past(pend[SEL_CTRL]) &&
             live_hgt == $past(pend[SEL_HGT])));

    assert_live_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_armed && vblank) |=>
            ($stable(live_ctrl) && $stable(live_pos) &&
             $stable(live_base) && $stable(live_hgt)));

    assert_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(live_width) && (live_enable == (live_width != '0)));

    assert_square_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_enable && !live_hgt[DATA_W-1]) |-> live_height == live_width);
endmodule

bind cur_arm_bank cur_arm_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .vblank      (vblank),
    .upd_armed   (upd_armed),
    .pend        (pend),
    .live_ctrl   (live_ctrl),
    .live_pos    (live_pos),
    .live_base   (live_base),
    .live_hgt    (live_hgt),
    .live_enable (live_enable),
    .live_width  (live_width),
    .live_height (live_height)
);

// File: tb/cur_arm_bank_test.sv
`timescale 1ns/1ps
module cur_arm_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        upd_armed;
    logic        vblank = 1'b0;
    logic [31:0] live_ctrl, live_pos, live_base, live_hgt;
    logic        live_enable;
    logic [8:0]  live_width, live_height;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cur_arm_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .upd_armed(upd_armed), .vblank(vblank), .live_ctrl(live_ctrl),
        .live_pos(live_pos), .live_base(live_base), .live_hgt(live_hgt),
        .live_enable(live_enable), .live_width(live_width),
        .live_height(live_height)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vbl();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 armed", {31'd0, upd_armed}, 32'd0);
        chk("R1 live_ctrl", live_ctrl, 32'd0);
        chk("R1 live_base", live_base, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd_addr = 2'(i); #1;
            chk("R1 pending", rd_data, 32'd0);
        end
    endtask

    task automatic t_pos_alone();
        wr(2'd1, 32'h0010_0020);
        chk("R7 no arm", {31'd0, upd_armed}, 32'd0);
        vbl();
        chk("R7 live_pos", live_pos, 32'd0);
        vbl();
        chk("R6 live_pos idle vblank", live_pos, 32'd0);
    endtask

    task automatic t_enable();
        wr(2'd0, 32'd1);
        chk("R3 armed", {31'd0, upd_armed}, 32'd1);
        vbl();
        chk("R5 live_ctrl", live_ctrl, 32'd1);
        chk("R5 live_pos", live_pos, 32'h0010_0020);
        chk("R5 armed clear", {31'd0, upd_armed}, 32'd0);
        chk("R9 width 64", {23'd0, live_width}, 32'd64);
        chk("R10 square 64", {23'd0, live_height}, 32'd64);
    endtask

    task automatic t_base_arm();
        wr(2'd2, 32'h0000_8000);
        chk("R2 armed", {31'd0, upd_armed}, 32'd1);
        vbl();
        chk("R5 live_base", live_base, 32'h0000_8000);
    endtask

    task automatic t_cancel();
        wr(2'd2, 32'h0000_9000);
        wr(2'd1, 32'h0005_0005);
        chk("R4 cancelled", {31'd0, upd_armed}, 32'd0);
        vbl();
        chk("R6 live_base held", live_base, 32'h0000_8000);
        chk("R6 live_pos held", live_pos, 32'h0010_0020);
        wr(2'd2, 32'h0000_9000);
        vbl();
        chk("R5 live_base rearm", live_base, 32'h0000_9000);
        chk("R5 live_pos rearm", live_pos, 32'h0005_0005);
    endtask

    task automatic t_ctrl_no_arm();
        wr(2'd0, 32'd2);
        chk("R4 ctrl no arm", {31'd0, upd_armed}, 32'd0);
        vbl();
        chk("R4 width unchanged", {23'd0, live_width}, 32'd64);
        wr(2'd2, 32'h0000_9000);
        vbl();
        chk("R9 width 128", {23'd0, live_width}, 32'd128);
        chk("R10 square 128", {23'd0, live_height}, 32'd128);
    endtask

    task automatic t_height();
        wr(2'd3, 32'h8000_001F);
        wr(2'd2, 32'h0000_9000);
        vbl();
        chk("R10 override height", {23'd0, live_height}, 32'd32);
        chk("R10 width kept", {23'd0, live_width}, 32'd128);
        wr(2'd3, 32'h0000_001F);
        wr(2'd2, 32'h0000_9000);
        vbl();
        chk("R10 override off", {23'd0, live_height}, 32'd128);
    endtask

    task automatic t_read();
        wr(2'd1, 32'h0000_1234);
        rd_addr = 2'd0; #1; chk("R8 read ctrl", rd_data, 32'd2);
        rd_addr = 2'd1; #1; chk("R8 read pos", rd_data, 32'h0000_1234);
        rd_addr = 2'd2; #1; chk("R8 read base", rd_data, 32'h0000_9000);
        rd_addr = 2'd3; #1; chk("R8 read hgt", rd_data, 32'h0000_001F);
        chk("R8 live pos not pending", live_pos, 32'h0005_0005);
    endtask

    task automatic t_modes();
        wr(2'd0, 32'd3);
        wr(2'd2, 32'h0000_A000);
        vbl();
        chk("R9 width 256", {23'd0, live_width}, 32'd256);
        chk("R10 square 256", {23'd0, live_height}, 32'd256);
        wr(2'd0, 32'd0);
        wr(2'd2, 32'h0000_A000);
        vbl();
        chk("R9 disabled", {31'd0, live_enable}, 32'd0);
        chk("R9 width 0", {23'd0, live_width}, 32'd0);
        wr(2'd0, 32'd1);
        chk("R3 rearm from disabled", {31'd0, upd_armed}, 32'd1);
        wr(2'd3, 32'h8000_0007);
        chk("R4 height write cancels", {31'd0, upd_armed}, 32'd0);
        vbl();
        chk("R6 stays disabled", live_ctrl, 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pos_alone();
        t_enable();
        t_base_arm();
        t_cancel();
        t_ctrl_no_arm();
        t_height();
        t_read();
        t_modes();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule